// File: doc/BRIEF.md
# Ordered Byte Load/Store Unit

This execution unit carries out one class of byte-wide memory instructions. It takes a decoded instruction and the register values it needs. The instruction fields are a 2-bit operation code, a prefetch flag, a 5-bit base index, a 5-bit target index and a 9-bit immediate. The register values are the base register, the stack pointer and the target register. From these the unit forms a 64-bit effective address by adding the sign-extended immediate to the base. It then performs one of three actions: a one-byte store, a one-byte load whose result is zero- or sign-extended into a 32- or 64-bit destination, or a prefetch hint.

Memory is reached through one request channel and one response channel, each with a valid/ready handshake. Each request is tagged with an access kind, an ordered-access attribute and a tag-check flag. When a base index of 31 is used for a load or store, the stack pointer is checked for alignment. A misaligned stack pointer raises a one-cycle fault and the unit sends no request. The unit works on one instruction at a time. A load ends with a one-cycle register write-back.

Top module: `ordbyte_ldst`

## Requirements
- R1: The request address equals the base value plus the 9-bit immediate sign-extended to 64 bits (offset -256..255), wrapping modulo 2^64. A base index of 31 takes the stack pointer value in place of the base register value.
- R2: With the prefetch flag low, the operation code is decoded as follows. 00 is a store. 01 is a load zero-extended to 32 bits. 10 is a load sign-extended to 64 bits. 11 is a load sign-extended to 32 bits. With the prefetch flag high, the operation is a prefetch whatever the operation code.
- R3: A store issues a request with kind code 1 and size code 0 (one byte), and its write data is bits 7:0 of the target register value.
- R4: A load issues a request with kind code 0 and size code 0. After the response is accepted, write-back valid is high for exactly one cycle, carrying the target index and the extended byte. Bits 63:32 are zero for 32-bit destinations.
- R5: A load or store with base index 31 and a stack pointer whose bits 3:0 are nonzero pulses the alignment fault for one cycle. It issues no request and no write-back. A prefetch never performs this check.
- R6: The request tag-check flag is 1 exactly when the operation is not a prefetch and the base index is not 31.
- R7: The ordered-access attribute is 1 on load and store requests and 0 on prefetch requests.
- R8: A prefetch issues a request with kind code 2 whose hint field equals the target index. It produces no write-back, and the unit is idle again once the request is accepted.
- R9: A request stays valid with unchanged fields until it is accepted. A load produces no write-back before the response is valid. The instruction input is ready only while the unit is idle.
- R10: After reset the unit is idle and ready, with request valid, write-back valid and alignment fault all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit idle, instruction accepted this cycle if valid |
| in_opc | input | 2 | Operation code |
| in_pref | input | 1 | Instruction is a prefetch |
| in_base | input | 5 | Base register index (31 = stack pointer) |
| in_tgt | input | 5 | Target register index / prefetch hint |
| in_imm | input | 9 | Signed byte offset |
| base_val | input | 64 | Base register value |
| sp_val | input | 64 | Stack pointer value |
| tgt_val | input | 64 | Target register value (store data source) |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_kind | output | 2 | 0 load, 1 store, 2 prefetch |
| req_addr | output | 64 | Byte address |
| req_wdata | output | 8 | Store byte |
| req_size | output | 2 | Access size code (0 = one byte) |
| req_ordered | output | 1 | Ordered-access attribute |
| req_tagchk | output | 1 | Tag-check flag |
| req_hint | output | 5 | Prefetch hint |
| rsp_valid | input | 1 | Load data valid |
| rsp_data | input | 8 | Load data byte |
| wb_valid | output | 1 | Register write-back valid |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | 64 | Write-back value |
| align_fault | output | 1 | Stack-pointer alignment fault pulse |

## Verification
The bench builds the unit with its default parameters: a 64-bit register width, a 32-bit narrow destination, a 9-bit immediate and a 4-bit alignment field. With these values both ends of the immediate range and address wrap-around can be tested. The bench also covers sign extension across bit 31 versus bit 63, and stack pointers that are aligned and misaligned in their low four bits. The bench stalls the request and response channels for several cycles, which exercises the hold and wait behaviour.

// File: rtl/ordbyte_pkg.sv
package ordbyte_pkg;
  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_PREF  = 2'd2
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e kind;
    logic      sext;
    logic      narrow;
    logic      use_sp;
    logic      tag_chk;
    logic      chk_align;
  } dec_t;

  localparam logic [1:0] SIZE_ONE_BYTE = 2'd0;
endpackage

// File: rtl/ordbyte_decode.sv
module ordbyte_decode
  import ordbyte_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic [1:0]           opc,
  input  logic                 pref,
  input  logic [REG_IDX_W-1:0] base_idx,
  output dec_t                 dec
);
  localparam logic [REG_IDX_W-1:0] SP_IDX = '1;

  always_comb begin
    dec        = '0;
    dec.use_sp = (base_idx == SP_IDX);
    if (pref) begin
      dec.kind = KIND_PREF;
    end else if (!opc[1]) begin
      dec.kind   = opc[0] ? KIND_LOAD : KIND_STORE;
      dec.narrow = 1'b1;
    end else begin
      dec.kind   = KIND_LOAD;
      dec.sext   = 1'b1;
      dec.narrow = opc[0];
    end
    dec.tag_chk   = (dec.kind != KIND_PREF) && !dec.use_sp;
    dec.chk_align = (dec.kind != KIND_PREF) && dec.use_sp;
  end
endmodule

// File: rtl/ordbyte_agen.sv
module ordbyte_agen #(
  parameter int XLEN      = 64,
  parameter int IMM_W     = 9,
  parameter int ALIGN_LSB = 4
) (
  input  logic             use_sp,
  input  logic             chk_align,
  input  logic [XLEN-1:0]  base_val,
  input  logic [XLEN-1:0]  sp_val,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  addr,
  output logic             misaligned
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] base_sel;

  assign offset     = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign base_sel   = use_sp ? sp_val : base_val;
  assign addr       = base_sel + offset;
  assign misaligned = chk_align && (|sp_val[ALIGN_LSB-1:0]);
endmodule

// File: rtl/ordbyte_extend.sv
module ordbyte_extend #(
  parameter int XLEN     = 64,
  parameter int NARROW_W = 32
) (
  input  logic [7:0]      data,
  input  logic            sext,
  input  logic            narrow,
  output logic [XLEN-1:0] result
);
  logic [XLEN-1:0] wide;

  assign wide = sext ? {{(XLEN-8){data[7]}}, data} : {{(XLEN-8){1'b0}}, data};

  generate
    if (XLEN > NARROW_W) begin : g_clip
      assign result = narrow ? {{(XLEN-NARROW_W){1'b0}}, wide[NARROW_W-1:0]} : wide;
    end else begin : g_same
      logic unused_narrow;
      assign unused_narrow = narrow;
      assign result = wide;
    end
  endgenerate
endmodule

// File: rtl/ordbyte_ldst.sv
module ordbyte_ldst
  import ordbyte_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int NARROW_W  = 32,
  parameter int REG_IDX_W = 5,
  parameter int IMM_W     = 9,
  parameter int ALIGN_LSB = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           in_opc,
  input  logic                 in_pref,
  input  logic [REG_IDX_W-1:0] in_base,
  input  logic [REG_IDX_W-1:0] in_tgt,
  input  logic [IMM_W-1:0]     in_imm,
  input  logic [XLEN-1:0]      base_val,
  input  logic [XLEN-1:0]      sp_val,
  input  logic [XLEN-1:0]      tgt_val,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [1:0]           req_kind,
  output logic [XLEN-1:0]      req_addr,
  output logic [7:0]           req_wdata,
  output logic [1:0]           req_size,
  output logic                 req_ordered,
  output logic                 req_tagchk,
  output logic [REG_IDX_W-1:0] req_hint,
  input  logic                 rsp_valid,
  input  logic [7:0]           rsp_data,
  output logic                 wb_valid,
  output logic [REG_IDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]      wb_data,
  output logic                 align_fault
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RESP} state_e;

  state_e                 state;
  dec_t                   dec;
  logic [XLEN-1:0]        ea;
  logic                   misaligned;
  logic [XLEN-1:0]        ext_val;
  logic                   pend_sext;
  logic                   pend_narrow;
  logic [REG_IDX_W-1:0]   pend_idx;
  logic                   unused_tgt_hi;

  assign unused_tgt_hi = ^tgt_val[XLEN-1:8];

  ordbyte_decode #(.REG_IDX_W(REG_IDX_W)) u_dec (
    .opc(in_opc), .pref(in_pref), .base_idx(in_base), .dec(dec)
  );

  ordbyte_agen #(.XLEN(XLEN), .IMM_W(IMM_W), .ALIGN_LSB(ALIGN_LSB)) u_agen (
    .use_sp(dec.use_sp), .chk_align(dec.chk_align), .base_val(base_val),
    .sp_val(sp_val), .imm(in_imm), .addr(ea), .misaligned(misaligned)
  );

  ordbyte_extend #(.XLEN(XLEN), .NARROW_W(NARROW_W)) u_ext (
    .data(rsp_data), .sext(pend_sext), .narrow(pend_narrow), .result(ext_val)
  );

  assign in_ready = (state == ST_IDLE);
  assign req_size = SIZE_ONE_BYTE;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      req_valid   <= 1'b0;
      req_kind    <= KIND_LOAD;
      req_addr    <= '0;
      req_wdata   <= '0;
      req_ordered <= 1'b0;
      req_tagchk  <= 1'b0;
      req_hint    <= '0;
      wb_valid    <= 1'b0;
      wb_idx      <= '0;
      wb_data     <= '0;
      align_fault <= 1'b0;
      pend_sext   <= 1'b0;
      pend_narrow <= 1'b0;
      pend_idx    <= '0;
    end else begin
      wb_valid    <= 1'b0;
      align_fault <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            if (misaligned) begin
              align_fault <= 1'b1;
            end else begin
              req_valid   <= 1'b1;
              req_kind    <= dec.kind;
              req_addr    <= ea;
              req_wdata   <= (dec.kind == KIND_STORE) ? tgt_val[7:0] : 8'h00;
              req_ordered <= (dec.kind != KIND_PREF);
              req_tagchk  <= dec.tag_chk;
              req_hint    <= in_tgt;
              pend_sext   <= dec.sext;
              pend_narrow <= dec.narrow;
              pend_idx    <= in_tgt;
              state       <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (req_ready) begin
            req_valid <= 1'b0;
            state     <= (req_kind == KIND_LOAD) ? ST_RESP : ST_IDLE;
          end
        end
        ST_RESP: begin
          if (rsp_valid) begin
            wb_valid <= 1'b1;
            wb_idx   <= pend_idx;
            wb_data  <= ext_val;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_fault_blocks_req_R5: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> (!req_valid && !wb_valid));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_kind) && $stable(req_wdata)));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !in_ready);

  assert_wb_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    wb_valid |=> !wb_valid);

  assert_ordered_mem_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind != KIND_PREF) |-> req_ordered);

  assert_pref_plain_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == KIND_PREF) |-> (!req_tagchk && !req_ordered));
endmodule

// File: tb/ordbyte_ldst_test.sv
`timescale 1ns/1ps
module ordbyte_ldst_test;
  typedef struct {
    logic [1:0]  kind;
    logic [63:0] addr;
    logic [7:0]  wdata;
    logic        tagchk;
    logic        ordered;
    logic [4:0]  hint;
    string       tag;
  } req_exp_t;

  typedef struct {
    logic [4:0]  idx;
    logic [63:0] data;
    string       tag;
  } wb_exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_opc = '0;
  logic        in_pref = 1'b0;
  logic [4:0]  in_base = '0, in_tgt = '0;
  logic [8:0]  in_imm = '0;
  logic [63:0] base_val = '0, sp_val = '0, tgt_val = '0;
  logic        req_valid, req_ready = 1'b0;
  logic [1:0]  req_kind, req_size;
  logic [63:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ordered, req_tagchk;
  logic [4:0]  req_hint;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_data = '0;
  logic        wb_valid;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;
  logic        align_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  req_exp_t req_q[$];
  wb_exp_t  wb_q[$];
  int       fault_q[$];

  always #4 clk = ~clk;

  ordbyte_ldst uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_opc(in_opc), .in_pref(in_pref), .in_base(in_base), .in_tgt(in_tgt),
    .in_imm(in_imm), .base_val(base_val), .sp_val(sp_val), .tgt_val(tgt_val),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_size(req_size),
    .req_ordered(req_ordered), .req_tagchk(req_tagchk), .req_hint(req_hint),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_data(wb_data), .align_fault(align_fault)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: samples 2 ns after each falling edge, pops the scoreboard
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (req_valid && req_ready) begin
        if (req_q.size() == 0) begin
          check(1'b0, "R5/R8", "unexpected request", req_addr, 64'h0);
        end else begin
          req_exp_t e;
          e = req_q.pop_front();
          check(req_kind == e.kind, e.tag, "req kind", {62'h0, req_kind}, {62'h0, e.kind});
          check(req_addr == e.addr, e.tag, "req addr (R1)", req_addr, e.addr);
          check(req_size == 2'd0, e.tag, "req size (R3)", {62'h0, req_size}, 64'h0);
          if (e.kind == 2'd1)
            check(req_wdata == e.wdata, e.tag, "store data (R3)", {56'h0, req_wdata}, {56'h0, e.wdata});
          check(req_tagchk == e.tagchk, e.tag, "tag check (R6)", {63'h0, req_tagchk}, {63'h0, e.tagchk});
          check(req_ordered == e.ordered, e.tag, "ordered (R7)", {63'h0, req_ordered}, {63'h0, e.ordered});
          if (e.kind == 2'd2)
            check(req_hint == e.hint, e.tag, "hint (R8)", {59'h0, req_hint}, {59'h0, e.hint});
        end
      end
      if (wb_valid) begin
        if (wb_q.size() == 0) begin
          check(1'b0, "R8", "unexpected write-back", wb_data, 64'h0);
        end else begin
          wb_exp_t w;
          w = wb_q.pop_front();
          check(wb_idx == w.idx, w.tag, "wb index (R4)", {59'h0, wb_idx}, {59'h0, w.idx});
          check(wb_data == w.data, w.tag, "wb data (R2)", wb_data, w.data);
        end
      end
      if (align_fault) begin
        if (fault_q.size() == 0) check(1'b0, "R5", "unexpected fault", 64'h1, 64'h0);
        else void'(fault_q.pop_front());
      end
    end
  end

  task automatic issue(input logic [1:0] opc, input logic pf, input logic [4:0] base,
                       input logic [4:0] tgt, input logic [8:0] imm,
                       input logic [63:0] bval, input logic [63:0] spv,
                       input logic [63:0] tval, input int stall,
                       input logic [7:0] rbyte, input string tag);
    bit use_sp, fault, is_load;
    logic [1:0] kind;
    logic [63:0] ea, wbv;
    req_exp_t e;
    wb_exp_t w;
    use_sp = (base == 5'd31);
    kind = pf ? 2'd2 : ((opc == 2'b00) ? 2'd1 : 2'd0);
    is_load = (kind == 2'd0);
    ea = (use_sp ? spv : bval) + {{55{imm[8]}}, imm};
    fault = use_sp && !pf && (spv[3:0] != 4'h0);
    case (opc)
      2'b01:   wbv = {56'h0, rbyte};
      2'b10:   wbv = {{56{rbyte[7]}}, rbyte};
      default: wbv = {32'h0, {24{rbyte[7]}}, rbyte};
    endcase
    if (fault) begin
      fault_q.push_back(1);
    end else begin
      e.kind = kind; e.addr = ea; e.wdata = tval[7:0];
      e.tagchk = !pf && !use_sp; e.ordered = !pf; e.hint = tgt; e.tag = tag;
      req_q.push_back(e);
      if (is_load) begin
        w.idx = tgt; w.data = wbv; w.tag = tag;
        wb_q.push_back(w);
      end
    end
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_opc = opc; in_pref = pf; in_base = base; in_tgt = tgt; in_imm = imm;
    base_val = bval; sp_val = spv; tgt_val = tval; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (fault) begin
      #3;
      check(fault_q.size() == 0, "R5", "fault pulse seen", {63'h0, align_fault}, 64'h1);
      check(!req_valid, "R5", "no request on fault", {63'h0, req_valid}, 64'h0);
      @(negedge clk);
      #3;
      check(!align_fault && !req_valid && !wb_valid, "R5", "fault single cycle, no traffic",
            {63'h0, align_fault}, 64'h0);
      return;
    end
    for (int i = 0; i < stall; i++) begin
      #3;
      check(req_valid && !in_ready, "R9", "request held while stalled", {63'h0, req_valid}, 64'h1);
      @(negedge clk);
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    if (is_load) begin
      for (int i = 0; i < stall; i++) begin
        #3;
        check(!wb_valid && !in_ready, "R9", "load waits for response", {63'h0, wb_valid}, 64'h0);
        @(negedge clk);
      end
      rsp_valid = 1'b1; rsp_data = rbyte;
      @(negedge clk);
      rsp_valid = 1'b0;
      #3;
      check(wb_q.size() == 0, "R4", "write-back produced", {63'h0, wb_valid}, 64'h1);
      @(negedge clk);
      #3;
      check(!wb_valid, "R4", "write-back single cycle", {63'h0, wb_valid}, 64'h0);
    end else begin
      #3;
      check(in_ready && !req_valid, "R8", "idle after accept", {63'h0, in_ready}, 64'h1);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(in_ready && !req_valid && !wb_valid && !align_fault, "R10", "reset state",
          {60'h0, in_ready, req_valid, wb_valid, align_fault}, 64'h8);
    // R3 store, max positive offset, stalled request
    issue(2'b00, 1'b0, 5'd4, 5'd9, 9'h0FF, 64'h0000_0000_0001_0000, 64'h0,
          64'hDEAD_BEEF_CAFE_12A5, 2, 8'h00, "R3");
    // R2 zero-extending 32-bit load
    issue(2'b01, 1'b0, 5'd2, 5'd7, 9'h010, 64'h2000, 64'h0, 64'h0, 1, 8'hF3, "R2 zext32");
    // R2 sign-extending 64-bit load of a negative byte
    issue(2'b10, 1'b0, 5'd3, 5'd1, 9'h000, 64'h3000, 64'h0, 64'h0, 3, 8'h80, "R2 sext64");
    // R4 sign-extending 32-bit load: upper word must be clear
    issue(2'b11, 1'b0, 5'd5, 5'd30, 9'h001, 64'h4000, 64'h0, 64'h0, 0, 8'h9C, "R4 sext32");
    // R2 sign-extending 64-bit load of a positive byte
    issue(2'b10, 1'b0, 5'd6, 5'd11, 9'h002, 64'h5000, 64'h0, 64'h0, 0, 8'h7F, "R2 sext64 pos");
    // R1 stack pointer base, most negative offset, tag check off
    issue(2'b01, 1'b0, 5'd31, 5'd12, 9'h100, 64'hFFFF, 64'h1000, 64'h0, 1, 8'h55, "R1 sp");
    // R1 address wrap: zero base, offset -1
    issue(2'b00, 1'b0, 5'd8, 5'd13, 9'h1FF, 64'h0, 64'h0, 64'h77, 0, 8'h00, "R1 wrap");
    // R5 misaligned stack pointer store and load
    issue(2'b00, 1'b0, 5'd31, 5'd14, 9'h004, 64'h0, 64'h1008, 64'h11, 0, 8'h00, "R5 store");
    issue(2'b11, 1'b0, 5'd31, 5'd15, 9'h000, 64'h0, 64'h2001, 64'h0, 0, 8'hAA, "R5 load");
    // R8 prefetch through misaligned stack pointer: no fault, no write-back
    issue(2'b01, 1'b1, 5'd31, 5'd19, 9'h020, 64'h0, 64'h3003, 64'h0, 2, 8'h00, "R8 sp");
    // R8 prefetch with a load operation code, general base
    issue(2'b11, 1'b1, 5'd10, 5'd21, 9'h1F0, 64'h8000, 64'h0, 64'h0, 0, 8'h00, "R8 gpr");
    // R6 store with base 30 keeps the tag check
    issue(2'b00, 1'b0, 5'd30, 5'd2, 9'h008, 64'h9000, 64'h0, 64'h3C, 1, 8'h00, "R6");
    repeat (3) @(negedge clk);
    #3;
    check(req_q.size() == 0 && wb_q.size() == 0 && fault_q.size() == 0, "R9",
          "scoreboard drained", req_q.size() + wb_q.size(), 64'h0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual %h expected %h", 64'h0, 64'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule